// File: doc/BRIEF.md
# Quadword Address and Stack Unit

This unit forms memory addresses for a processor subset in which every memory word is a 64-bit quadword. For an ordinary memory operand, it adds three optional parts modulo 2^64: a base register value, an index register value multiplied by 8, and a signed 32-bit displacement. For the four stack operations (push, pop, call and return), it steps the stack pointer by one quadword in the required order. It also issues the single memory read or write that goes with each operation. Instruction decode and the memory array belong to other blocks.

An operation starts with a one-cycle `start` pulse, and the unit captures every operand input on that edge. The sequence then runs through named states:

- IDLE goes to CALC on `start`.
- CALC forms the address, the fault and the next stack pointer. It goes to ACCESS when a memory access is needed, and to FINISH otherwise.
- ACCESS drives one read or write cycle. A return goes on to RETWAIT; every other operation goes to FINISH.
- RETWAIT takes the returned data as the new program counter, then goes to FINISH.
- FINISH raises `done` for one cycle and goes back to IDLE.

Illegal forms raise `fault` and block the memory access. The illegal forms are an index register equal to the stack pointer, a misaligned data address, a misaligned stack pointer, and an unused operation code.

Top module: `qw_agu`

## Requirements
- R1: After reset, `done`, `fault`, `mem_rd`, `mem_wr` and `pc_we` are 0, and no memory access happens while `start` stays low.
- R2: The effective address is (base if `base_en`) + (index × 8 if `idx_en`) + the sign-extended displacement, wrapping modulo 2^64. Operation code 2 (address only) reports this value on `ea` and makes no memory access.
- R3: Operation code 0 (read) asserts `mem_rd` for one cycle at `mem_addr` = effective address. Operation code 1 (write) asserts `mem_wr` for one cycle at that address with `mem_wdata` = `src_val`. `mem_rd` and `mem_wr` are never high together.
- R4: For operation codes 0, 1 and 2, `idx_en` high with `idx_num` equal to SP_NUM (4 by default) raises `fault` and makes no access. The same register number is legal when `idx_en` is low.
- R5: For operation codes 0 and 1, a nonzero value in bits [2:0] of the effective address raises `fault` and makes no access. Operation code 2 is not checked for alignment.
- R6: Push (code 3) writes `src_val` at `sp_val` − 8 and reports `sp_next` = `ea` = `sp_val` − 8.
- R7: Pop (code 4) reads at `sp_val` and reports `ea` = `sp_val` and `sp_next` = `sp_val` + 8.
- R8: Call (code 5) writes `pc_val` at `sp_val` − 8, reports `sp_next` = `sp_val` − 8 and `pc_next` = `target_val`, and pulses `pc_we` with `done`.
- R9: Return (code 6) reads at `sp_val` and reports `sp_next` = `sp_val` + 8. `pc_next` takes the `mem_rdata` value present in the cycle after the read, and `pc_we` pulses with `done`.
- R10: A stack operation (codes 3 to 6) whose `sp_val` has nonzero bits [2:0] raises `fault`, makes no access, keeps `sp_next` = `sp_val` and `pc_next` = `pc_val`, and leaves `pc_we` low.
- R11: `done` is a one-cycle pulse. Counting from the edge that samples `start`, it is high in the 2nd cycle for an operation with no access, in the 3rd cycle for an operation with an access, and in the 4th cycle for a return.
- R12: Operation code 7 always raises `fault` and makes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (accepted in IDLE) |
| op | input | 3 | Operation code: 0 read, 1 write, 2 address only, 3 push, 4 pop, 5 call, 6 return |
| base_en | input | 1 | Base term present |
| base_val | input | 64 | Base register value |
| idx_en | input | 1 | Index term present |
| idx_val | input | 64 | Index register value |
| idx_num | input | 4 | Index register number |
| disp | input | 32 | Signed displacement |
| sp_val | input | 64 | Current stack pointer |
| pc_val | input | 64 | Current program counter |
| target_val | input | 64 | Call target |
| src_val | input | 64 | Write or push data |
| mem_rdata | input | 64 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | Operation complete |
| fault | output | 1 | Illegal form detected |
| ea | output | 64 | Effective or stack access address |
| sp_next | output | 64 | Next stack pointer |
| pc_next | output | 64 | Next program counter |
| pc_we | output | 1 | Program counter update strobe |
| mem_addr | output | 64 | Memory access address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 64 | Memory write data |

## Verification
A wrong state register shows up at the ports within one operation. A skipped or repeated state moves the `done` pulse away from its fixed 2-, 3- or 4-cycle position, and it also adds or drops a `mem_rd`/`mem_wr` cycle. A wrong fault decision shows up in the same operation, as a stray access or a missing one. Address or stack-step errors appear on `mem_addr` in the ACCESS cycle and on `ea`/`sp_next` in the FINISH cycle. The bench therefore sweeps every operation code across present and absent operands, a range of index register numbers, displacements at the signed extremes, and aligned and misaligned stack pointers. It compares latency, access kind, address, data and results against values computed arithmetically in the bench.

// File: rtl/qwagu_pkg.sv
`timescale 1ns/1ps
package qwagu_pkg;
    typedef enum logic [2:0] {
        OP_RD   = 3'd0,
        OP_WR   = 3'd1,
        OP_LEA  = 3'd2,
        OP_PUSH = 3'd3,
        OP_POP  = 3'd4,
        OP_CALL = 3'd5,
        OP_RET  = 3'd6,
        OP_BAD  = 3'd7
    } agu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CALC    = 3'd1,
        ST_ACCESS  = 3'd2,
        ST_RETWAIT = 3'd3,
        ST_FINISH  = 3'd4
    } agu_state_e;
endpackage

// File: rtl/qwagu_ea_calc.sv
`timescale 1ns/1ps
module qwagu_ea_calc #(
    parameter int XLEN   = 64,
    parameter int DISPW  = 32,
    parameter int RNUMW  = 4,
    parameter int SP_NUM = 4,
    parameter int SH     = 3
) (
    input  logic             base_en,
    input  logic [XLEN-1:0]  base_val,
    input  logic             idx_en,
    input  logic [XLEN-1:0]  idx_val,
    input  logic [RNUMW-1:0] idx_num,
    input  logic [DISPW-1:0] disp,
    output logic [XLEN-1:0]  ea,
    output logic             idx_bad,
    output logic             misal
);
    localparam int EXTW = XLEN - DISPW;

    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] idx_term;
    logic [XLEN-1:0] disp_term;

    always_comb begin
        base_term = base_en ? base_val : '0;
        idx_term  = idx_en ? (idx_val << SH) : '0;
        disp_term = {{EXTW{disp[DISPW-1]}}, disp};
        ea        = base_term + idx_term + disp_term;
        idx_bad   = idx_en && (idx_num == RNUMW'(SP_NUM));
        misal     = |ea[SH-1:0];
    end
endmodule

// File: rtl/qwagu_stack_calc.sv
`timescale 1ns/1ps
module qwagu_stack_calc #(
    parameter int XLEN       = 64,
    parameter int SLOT_BYTES = 8,
    parameter int SH         = 3
) (
    input  logic [XLEN-1:0] sp,
    input  logic            grow,
    output logic [XLEN-1:0] acc_addr,
    output logic [XLEN-1:0] sp_new,
    output logic            misal
);
    localparam logic [XLEN-1:0] SLOT = XLEN'(SLOT_BYTES);

    always_comb begin
        if (grow) begin
            sp_new   = sp - SLOT;
            acc_addr = sp_new;
        end else begin
            sp_new   = sp + SLOT;
            acc_addr = sp;
        end
        misal = |sp[SH-1:0];
    end
endmodule

// File: rtl/qw_agu.sv
`timescale 1ns/1ps
module qw_agu
    import qwagu_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int DISPW      = 32,
    parameter int RNUMW      = 4,
    parameter int SP_NUM     = 4,
    parameter int SLOT_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic             base_en,
    input  logic [XLEN-1:0]  base_val,
    input  logic             idx_en,
    input  logic [XLEN-1:0]  idx_val,
    input  logic [RNUMW-1:0] idx_num,
    input  logic [DISPW-1:0] disp,
    input  logic [XLEN-1:0]  sp_val,
    input  logic [XLEN-1:0]  pc_val,
    input  logic [XLEN-1:0]  target_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             done,
    output logic             fault,
    output logic [XLEN-1:0]  ea,
    output logic [XLEN-1:0]  sp_next,
    output logic [XLEN-1:0]  pc_next,
    output logic             pc_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [XLEN-1:0]  mem_wdata
);
    localparam int SH = $clog2(SLOT_BYTES);
    localparam logic [XLEN-1:0] SLOT = XLEN'(SLOT_BYTES);

    agu_state_e state, state_n;

    agu_op_e          op_q;
    logic             base_en_q, idx_en_q;
    logic [XLEN-1:0]  base_q, idx_q, sp_q, pc_q, tgt_q, src_q;
    logic [RNUMW-1:0] inum_q;
    logic [DISPW-1:0] disp_q;

    logic [XLEN-1:0]  addr_r, sp_r, pc_r;
    logic             fault_r;

    logic [XLEN-1:0]  ea_raw, st_addr, st_sp;
    logic             idx_bad, ea_mis, st_mis;
    logic             is_stack, is_grow, is_read, is_write;
    logic             fault_n, acc_n;
    logic [XLEN-1:0]  addr_n, sp_n, pc_n;

    qwagu_ea_calc #(
        .XLEN(XLEN), .DISPW(DISPW), .RNUMW(RNUMW), .SP_NUM(SP_NUM), .SH(SH)
    ) u_ea (
        .base_en (base_en_q),
        .base_val(base_q),
        .idx_en  (idx_en_q),
        .idx_val (idx_q),
        .idx_num (inum_q),
        .disp    (disp_q),
        .ea      (ea_raw),
        .idx_bad (idx_bad),
        .misal   (ea_mis)
    );

    qwagu_stack_calc #(
        .XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES), .SH(SH)
    ) u_stk (
        .sp      (sp_q),
        .grow    (is_grow),
        .acc_addr(st_addr),
        .sp_new  (st_sp),
        .misal   (st_mis)
    );

    // Operation classification and fault decision for the CALC state
    always_comb begin
        is_stack = (op_q == OP_PUSH) || (op_q == OP_POP) ||
                   (op_q == OP_CALL) || (op_q == OP_RET);
        is_grow  = (op_q == OP_PUSH) || (op_q == OP_CALL);
        is_read  = (op_q == OP_RD)   || (op_q == OP_POP) || (op_q == OP_RET);
        is_write = (op_q == OP_WR)   || (op_q == OP_PUSH) || (op_q == OP_CALL);
        unique case (op_q)
            OP_RD, OP_WR:                     fault_n = idx_bad | ea_mis;
            OP_LEA:                           fault_n = idx_bad;
            OP_PUSH, OP_POP, OP_CALL, OP_RET: fault_n = st_mis;
            default:                          fault_n = 1'b1;
        endcase
        acc_n  = !fault_n && (is_read || is_write);
        addr_n = is_stack ? st_addr : ea_raw;
        sp_n   = (is_stack && !fault_n) ? st_sp : sp_q;
        pc_n   = ((op_q == OP_CALL) && !fault_n) ? tgt_q : pc_q;
    end

    // Next-state logic
    always_comb begin
        unique case (state)
            ST_IDLE:    state_n = start ? ST_CALC : ST_IDLE;
            ST_CALC:    state_n = acc_n ? ST_ACCESS : ST_FINISH;
            ST_ACCESS:  state_n = (op_q == OP_RET) ? ST_RETWAIT : ST_FINISH;
            ST_RETWAIT: state_n = ST_FINISH;
            ST_FINISH:  state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Operand capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_RD;
            base_en_q <= 1'b0;
            idx_en_q  <= 1'b0;
            base_q    <= '0;
            idx_q     <= '0;
            inum_q    <= '0;
            disp_q    <= '0;
            sp_q      <= '0;
            pc_q      <= '0;
            tgt_q     <= '0;
            src_q     <= '0;
            addr_r    <= '0;
            sp_r      <= '0;
            pc_r      <= '0;
            fault_r   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q      <= agu_op_e'(op);
                        base_en_q <= base_en;
                        idx_en_q  <= idx_en;
                        base_q    <= base_val;
                        idx_q     <= idx_val;
                        inum_q    <= idx_num;
                        disp_q    <= disp;
                        sp_q      <= sp_val;
                        pc_q      <= pc_val;
                        tgt_q     <= target_val;
                        src_q     <= src_val;
                    end
                end
                ST_CALC: begin
                    addr_r  <= addr_n;
                    sp_r    <= sp_n;
                    pc_r    <= pc_n;
                    fault_r <= fault_n;
                end
                ST_RETWAIT: pc_r <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Port outputs
    always_comb begin
        done      = (state == ST_FINISH);
        fault     = fault_r;
        ea        = addr_r;
        sp_next   = sp_r;
        pc_next   = pc_r;
        pc_we     = done && !fault_r && ((op_q == OP_CALL) || (op_q == OP_RET));
        mem_addr  = addr_r;
        mem_rd    = (state == ST_ACCESS) && is_read;
        mem_wr    = (state == ST_ACCESS) && is_write;
        mem_wdata = (op_q == OP_CALL) ? pc_q : src_q;
    end

    // Checks on the sequence
    assert_one_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !fault);

    assert_aligned_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[SH-1:0] == '0));

    assert_idx_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CALC) && idx_en_q && (inum_q == RNUMW'(SP_NUM)) &&
         ((op_q == OP_RD) || (op_q == OP_WR) || (op_q == OP_LEA))) |=> fault);

    assert_push_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && ((op_q == OP_PUSH) || (op_q == OP_CALL)))
            |-> (sp_next + SLOT == sp_q));

    assert_pop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && ((op_q == OP_POP) || (op_q == OP_RET)))
            |-> (sp_next == sp_q + SLOT));

    assert_pc_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> done);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_bad_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_BAD)) |-> fault);
endmodule

// File: tb/qw_agu_test.sv
`timescale 1ns/1ps
module qw_agu_test;
    localparam logic [63:0] RKEY = 64'h5A5A_0F0F_3C3C_9696;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        base_en = 1'b0, idx_en = 1'b0;
    logic [63:0] base_val = '0, idx_val = '0, sp_val = '0, pc_val = '0;
    logic [63:0] target_val = '0, src_val = '0, mem_rdata = '0;
    logic [3:0]  idx_num = '0;
    logic [31:0] disp = '0;
    logic        done, fault, pc_we, mem_rd, mem_wr;
    logic [63:0] ea, sp_next, pc_next, mem_addr, mem_wdata;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    // Synchronous memory model: data returns the cycle after a read
    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_addr ^ RKEY;

    qw_agu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .base_en(base_en), .base_val(base_val), .idx_en(idx_en),
        .idx_val(idx_val), .idx_num(idx_num), .disp(disp),
        .sp_val(sp_val), .pc_val(pc_val), .target_val(target_val),
        .src_val(src_val), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .ea(ea), .sp_next(sp_next),
        .pc_next(pc_next), .pc_we(pc_we), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input int opc, input logic ben, input logic [63:0] bval,
                            input logic ien, input logic [63:0] ival,
                            input logic [3:0] inum, input logic [31:0] dv,
                            input logic [63:0] spv, input logic [63:0] pcv,
                            input logic [63:0] tgv, input logic [63:0] srcv);
        logic [63:0] e_ea, e_addr, e_sp, e_pc, e_wd;
        logic [63:0] a_addr, a_wd;
        logic        ibad, emis, smis, e_f, e_pcwe;
        int          e_acc, e_lat, n_acc, a_kind, lat;
        string       tag;
        e_ea = (ben ? bval : 64'd0) + (ien ? (ival << 3) : 64'd0) + {{32{dv[31]}}, dv};
        ibad = ien && (inum == 4'd4);
        emis = (e_ea[2:0] != 3'd0);
        smis = (spv[2:0] != 3'd0);
        e_sp = spv; e_pc = pcv; e_pcwe = 1'b0; e_wd = srcv; e_addr = e_ea;
        e_f = 1'b0; e_acc = 0; tag = "R2";
        case (opc)
            0: begin e_f = ibad | emis; e_acc = e_f ? 0 : 1;
                     tag = ibad ? "R4" : (emis ? "R5" : "R3"); end
            1: begin e_f = ibad | emis; e_acc = e_f ? 0 : 2;
                     tag = ibad ? "R4" : (emis ? "R5" : "R3"); end
            2: begin e_f = ibad; tag = ibad ? "R4" : "R2"; end
            3: begin e_f = smis; e_addr = spv - 64'd8; e_acc = e_f ? 0 : 2;
                     if (!e_f) e_sp = spv - 64'd8; tag = smis ? "R10" : "R6"; end
            4: begin e_f = smis; e_addr = spv; e_acc = e_f ? 0 : 1;
                     if (!e_f) e_sp = spv + 64'd8; tag = smis ? "R10" : "R7"; end
            5: begin e_f = smis; e_addr = spv - 64'd8; e_acc = e_f ? 0 : 2; e_wd = pcv;
                     if (!e_f) begin e_sp = spv - 64'd8; e_pc = tgv; e_pcwe = 1'b1; end
                     tag = smis ? "R10" : "R8"; end
            6: begin e_f = smis; e_addr = spv; e_acc = e_f ? 0 : 1;
                     if (!e_f) begin e_sp = spv + 64'd8; e_pc = spv ^ RKEY; e_pcwe = 1'b1; end
                     tag = smis ? "R10" : "R9"; end
            default: begin e_f = 1'b1; tag = "R12"; end
        endcase
        e_lat = (e_acc == 0) ? 2 : ((opc == 6) ? 4 : 3);

        @(negedge clk);
        op = 3'(opc); base_en = ben; base_val = bval; idx_en = ien; idx_val = ival;
        idx_num = inum; disp = dv; sp_val = spv; pc_val = pcv; target_val = tgv;
        src_val = srcv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1; n_acc = 0; a_kind = 0; a_addr = '0; a_wd = '0;
        while (!done && lat < 12) begin
            if (mem_rd || mem_wr) begin
                n_acc++;
                a_kind = mem_rd ? 1 : 2;
                a_addr = mem_addr;
                a_wd   = mem_wdata;
            end
            @(negedge clk);
            lat++;
        end
        chk(done && lat == e_lat, "R11", "latency", 64'(lat), 64'(e_lat));
        chk(fault == e_f, tag, "fault", 64'(fault), 64'(e_f));
        chk(ea == e_addr, tag, "ea", ea, e_addr);
        chk(sp_next == e_sp, tag, "sp_next", sp_next, e_sp);
        chk(pc_next == e_pc, tag, "pc_next", pc_next, e_pc);
        chk(pc_we == e_pcwe, tag, "pc_we", 64'(pc_we), 64'(e_pcwe));
        chk(n_acc == ((e_acc == 0) ? 0 : 1), tag, "access count", 64'(n_acc),
            64'((e_acc == 0) ? 0 : 1));
        if (e_acc != 0) begin
            chk(a_kind == e_acc, tag, "access kind", 64'(a_kind), 64'(e_acc));
            chk(a_addr == e_addr, tag, "mem_addr", a_addr, e_addr);
            if (e_acc == 2) chk(a_wd == e_wd, tag, "mem_wdata", a_wd, e_wd);
        end
    endtask

    initial begin
        #(8 * 190000);
        nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] dtab [6];
        dtab[0] = 32'h0000_0000; dtab[1] = 32'h0000_0008; dtab[2] = 32'hFFFF_FFF8;
        dtab[3] = 32'h7FFF_FFF8; dtab[4] = 32'h8000_0000; dtab[5] = 32'h0000_0005;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !fault && !pc_we, "R1", "status after reset",
            {61'd0, done, fault, pc_we}, 64'd0);
        chk(!mem_rd && !mem_wr, "R1", "strobes after reset",
            {62'd0, mem_rd, mem_wr}, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!mem_rd && !mem_wr && !done, "R1", "idle without start",
                {61'd0, mem_rd, mem_wr, done}, 64'd0);
        end

        // R2 wrap: base near the top plus positive displacement
        run_case(2, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 64'h2000_0000_0000_0001,
                 4'd2, 32'h0000_0010, 64'h100, 64'h40, 64'h80, 64'h1);
        // R6: push from zero wraps the stack pointer
        run_case(3, 1'b0, 64'd0, 1'b0, 64'd0, 4'd0, 32'd0,
                 64'd0, 64'h40, 64'h80, 64'hABCD);

        // Near-exhaustive sweep
        for (int opc = 0; opc < 8; opc++)
            for (int b = 0; b < 2; b++)
                for (int x = 0; x < 2; x++)
                    for (int n = 0; n < 4; n++)
                        for (int d = 0; d < 6; d++)
                            for (int s = 0; s < 2; s++) begin
                                logic [3:0] inum;
                                inum = (n == 0) ? 4'd0 : (n == 1) ? 4'd3 :
                                       (n == 2) ? 4'd4 : 4'd15;
                                run_case(opc, b[0], 64'hFFFF_FFFF_FFFF_FF00 + 64'(d * 8),
                                         x[0], 64'h1000_0000_0000_0003 + 64'(n),
                                         inum, dtab[d],
                                         64'h0000_0000_0001_0010 + 64'(d * 64) + 64'(s * 3),
                                         64'h4000 + 64'(opc * 8), 64'h8000_0000_0000_0040,
                                         64'hDEAD_BEEF_0000_0000 + 64'(d));
                            end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule